// File: doc/BRIEF.md
# Reduction Flow Tracking Table

This block keeps one record per reduction flow that is active at a node of a memory-side network. Each record is one node of a reduction tree that is built on the fly. It holds the port the flow first arrived from (the parent), a flag for each port the flow was forwarded to (the children), the opcode, a running partial result, a count of locally issued operations, a count of committed operations, and a gather flag. The packet processor sends events into the table one at a time over a valid/ready handshake. The table finds the record with a fully associative compare on the flow ID. It replicates gather requests toward the children. When a subtree has finished, it sends the partial result to the parent on its own and frees the record.

Packet parsing, route computation, operand fetch and the arithmetic of the local operations are outside the table. The table only folds committed results and child partial results into the record, using the opcode's combine function.

Top module: `flow_reduce_table`

## Requirements
- R1: After reset the table holds no flows, `evReady` is high, and `respValid` and `repValid` are low.
- R2: An update event (kind 0 = computed locally, kind 1 = forwarded) for a flow with no record allocates a free record. The record keeps the flow ID, the opcode `evOp` and `evPrevPort` as the parent port. A later update for the same flow leaves the parent and the opcode unchanged.
- R3: A forwarded update (kind 1) sets the child flag of port `evNextPort`. A gather request (kind 3) to a record whose child flags are not all clear produces a one-cycle `repValid` pulse in the cycle after acceptance, with `repFlow` and `repMask` (bit i = port i) equal to the child flags.
- R4: A local update (kind 0) adds one to the issued count. A commit event (kind 2) adds one to the committed count and folds `evData` into the partial result. A record never retires while the two counts differ.
- R5: Opcodes are 0 sum, 1 xor, 2 multiply-accumulate (results are added), 3 and, 4 unsigned minimum, 5 unsigned maximum. A new record's partial result starts at the identity of its opcode: zero for 0, 1 and 2, all ones for 3 and 4, zero for 5.
- R6: A gather response (kind 4) arriving from port `evPrevPort` folds `evData` into the partial result and clears that port's child flag.
- R7: When an accepted event leaves a record with its gather flag set, all child flags clear and equal counts, then in the next cycle `respValid` pulses for one cycle with the flow ID, the parent port and the updated partial result. The record is freed in the same step.
- R8: When all 16 records are in use, an update for an unknown flow holds `evReady` low and is not taken. Events for flows already in the table are still accepted, and the stall clears once a record is freed.
- R9: Commit, gather request and gather response events for a flow with no record are accepted and change nothing. They produce no output pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| evValid | input | 1 | Event offered |
| evReady | output | 1 | Event can be taken this cycle |
| evKind | input | 3 | Event kind (0..4) |
| evFlow | input | 8 | Flow ID of the event |
| evOp | input | 3 | Opcode, used when a record is allocated |
| evPrevPort | input | 2 | Port the packet arrived from |
| evNextPort | input | 2 | Port a forwarded update leaves on |
| evData | input | 16 | Committed result or child partial result |
| repValid | output | 1 | Gather request replication pulse |
| repFlow | output | 8 | Flow of the replicated gather |
| repMask | output | 4 | Ports that get the gather copy |
| respValid | output | 1 | Gather response to the parent |
| respFlow | output | 8 | Flow of the gather response |
| respPort | output | 2 | Parent port |
| respData | output | 16 | Reduced partial result |

## Verification
The main flow is driven with interleaved flows of every opcode. Some flows are purely local, some are purely forwarded, and some mix both with two children. This separates the fold operator and the identity value of each opcode, and shows whether a child's flag is tracked per port. The gather request is placed both before and after the last commit, and before and after the last child response, so retirement is shown to wait for every condition rather than fire on the gather alone. Finally the table is filled to capacity and events for unknown flows are offered. This separates a stall on allocation from the ignoring of non-update events.

// File: rtl/flow_reduce_pkg.sv
package flow_reduce_pkg;
  typedef enum logic [2:0] {
    EV_UPD_LOCAL = 3'd0,
    EV_UPD_FWD   = 3'd1,
    EV_COMMIT    = 3'd2,
    EV_GATH_REQ  = 3'd3,
    EV_GATH_RSP  = 3'd4
  } evKind_e;

  typedef enum logic [2:0] {
    OP_SUM = 3'd0,
    OP_XOR = 3'd1,
    OP_MAC = 3'd2,
    OP_AND = 3'd3,
    OP_MIN = 3'd4,
    OP_MAX = 3'd5
  } redOp_e;

  typedef struct packed {
    logic act;
    logic alloc;
    logic incIssue;
    logic incCommit;
    logic fold;
    logic setChild;
    logic clrChild;
    logic setGather;
    logic retire;
  } tblStrobe_t;
endpackage

// File: rtl/flow_reduce_ctrl.sv
module flow_reduce_ctrl
  import flow_reduce_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter int FLOW_W      = 8,
  parameter int NUM_PORTS   = 4,
  parameter int CNT_W       = 8,
  localparam int IDX_W      = $clog2(NUM_ENTRIES),
  localparam int PORT_W     = $clog2(NUM_PORTS)
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  logic                                evValid,
  output logic                                evReady,
  input  logic [2:0]                          evKind,
  input  logic [FLOW_W-1:0]                   evFlow,
  input  logic [PORT_W-1:0]                   evPrevPort,
  input  logic [PORT_W-1:0]                   evNextPort,
  input  logic [NUM_ENTRIES-1:0]              entryValid,
  input  logic [NUM_ENTRIES-1:0][FLOW_W-1:0]  entryFlow,
  input  logic [NUM_ENTRIES-1:0][NUM_PORTS-1:0] entryChild,
  input  logic [NUM_ENTRIES-1:0]              entryGather,
  input  logic [NUM_ENTRIES-1:0][CNT_W-1:0]   entryIssued,
  input  logic [NUM_ENTRIES-1:0][CNT_W-1:0]   entryCommitted,
  output tblStrobe_t                          strobe,
  output logic [IDX_W-1:0]                    strobeIdx
);
  logic [NUM_ENTRIES-1:0] hitVec;
  logic                   hit, full, isUpd, accept;
  logic [IDX_W-1:0]       hitIdx, freeIdx;
  logic [NUM_PORTS-1:0]   postChild;
  logic                   postGather, postEqual;
  logic [CNT_W-1:0]       postIss, postCom;

  always_comb begin
    hitIdx  = '0;
    freeIdx = '0;
    for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
      hitVec[i] = entryValid[i] && (entryFlow[i] == evFlow);
      if (hitVec[i]) hitIdx = IDX_W'(i);
      if (!entryValid[i]) freeIdx = IDX_W'(i);
    end
  end

  assign hit     = |hitVec;
  assign full    = &entryValid;
  assign isUpd   = (evKind == EV_UPD_LOCAL) || (evKind == EV_UPD_FWD);
  assign evReady = !(isUpd && !hit && full);
  assign accept  = evValid && evReady;
  assign strobeIdx = hit ? hitIdx : freeIdx;

  always_comb begin
    strobe           = '0;
    strobe.alloc     = accept && isUpd && !hit;
    strobe.act       = accept && (hit || strobe.alloc);
    strobe.incIssue  = strobe.act && (evKind == EV_UPD_LOCAL);
    strobe.setChild  = strobe.act && (evKind == EV_UPD_FWD);
    strobe.incCommit = strobe.act && (evKind == EV_COMMIT);
    strobe.fold      = strobe.act && ((evKind == EV_COMMIT) || (evKind == EV_GATH_RSP));
    strobe.clrChild  = strobe.act && (evKind == EV_GATH_RSP);
    strobe.setGather = strobe.act && (evKind == EV_GATH_REQ);
    postChild  = entryChild[hitIdx];
    if (strobe.clrChild) postChild[evPrevPort] = 1'b0;
    if (strobe.setChild) postChild[evNextPort] = 1'b1;
    postGather = entryGather[hitIdx] || strobe.setGather;
    postIss    = entryIssued[hitIdx] + CNT_W'(strobe.incIssue);
    postCom    = entryCommitted[hitIdx] + CNT_W'(strobe.incCommit);
    postEqual  = (postIss == postCom);
    strobe.retire = strobe.act && hit && postGather && (postChild == '0) && postEqual;
  end

  assert_stall_only_when_full_R8: assert property (@(posedge clk) disable iff (!rstN)
    (evValid && !evReady) |-> (&entryValid));
  assert_unique_match_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(hitVec));
endmodule

// File: rtl/flow_reduce_data.sv
module flow_reduce_data
  import flow_reduce_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter int FLOW_W      = 8,
  parameter int NUM_PORTS   = 4,
  parameter int DATA_W      = 16,
  parameter int CNT_W       = 8,
  localparam int IDX_W      = $clog2(NUM_ENTRIES),
  localparam int PORT_W     = $clog2(NUM_PORTS)
) (
  input  logic                                  clk,
  input  logic                                  rstN,
  input  tblStrobe_t                            strobe,
  input  logic [IDX_W-1:0]                      strobeIdx,
  input  logic [2:0]                            evKind,
  input  logic                                  evValid,
  input  logic [FLOW_W-1:0]                     evFlow,
  input  logic [2:0]                            evOp,
  input  logic [PORT_W-1:0]                     evPrevPort,
  input  logic [PORT_W-1:0]                     evNextPort,
  input  logic [DATA_W-1:0]                     evData,
  output logic [NUM_ENTRIES-1:0]                entryValid,
  output logic [NUM_ENTRIES-1:0][FLOW_W-1:0]    entryFlow,
  output logic [NUM_ENTRIES-1:0][NUM_PORTS-1:0] entryChild,
  output logic [NUM_ENTRIES-1:0]                entryGather,
  output logic [NUM_ENTRIES-1:0][CNT_W-1:0]     entryIssued,
  output logic [NUM_ENTRIES-1:0][CNT_W-1:0]     entryCommitted,
  output logic                                  repValid,
  output logic [FLOW_W-1:0]                     repFlow,
  output logic [NUM_PORTS-1:0]                  repMask,
  output logic                                  respValid,
  output logic [FLOW_W-1:0]                     respFlow,
  output logic [PORT_W-1:0]                     respPort,
  output logic [DATA_W-1:0]                     respData
);
  logic [NUM_ENTRIES-1:0][2:0]        entryOp;
  logic [NUM_ENTRIES-1:0][PORT_W-1:0] entryParent;
  logic [NUM_ENTRIES-1:0][DATA_W-1:0] entryResult;

  function automatic logic [DATA_W-1:0] identityOf(input logic [2:0] op);
    case (op)
      OP_AND, OP_MIN: identityOf = '1;
      default:        identityOf = '0;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] combine(input logic [2:0] op,
                                                input logic [DATA_W-1:0] a,
                                                input logic [DATA_W-1:0] b);
    case (op)
      OP_XOR:  combine = a ^ b;
      OP_AND:  combine = a & b;
      OP_MIN:  combine = (b < a) ? b : a;
      OP_MAX:  combine = (b > a) ? b : a;
      default: combine = a + b;
    endcase
  endfunction

  logic [2:0]           baseOp;
  logic [DATA_W-1:0]    baseResult, newResult;
  logic [NUM_PORTS-1:0] baseChild, newChild;
  logic [CNT_W-1:0]     baseIss, baseCom;
  logic                 baseGather;

  always_comb begin
    baseOp     = strobe.alloc ? evOp : entryOp[strobeIdx];
    baseResult = strobe.alloc ? identityOf(evOp) : entryResult[strobeIdx];
    baseChild  = strobe.alloc ? '0 : entryChild[strobeIdx];
    baseIss    = strobe.alloc ? '0 : entryIssued[strobeIdx];
    baseCom    = strobe.alloc ? '0 : entryCommitted[strobeIdx];
    baseGather = strobe.alloc ? 1'b0 : entryGather[strobeIdx];
    newResult  = strobe.fold ? combine(baseOp, baseResult, evData) : baseResult;
    newChild   = baseChild;
    if (strobe.clrChild) newChild[evPrevPort] = 1'b0;
    if (strobe.setChild) newChild[evNextPort] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      entryValid     <= '0;
      entryFlow      <= '0;
      entryOp        <= '0;
      entryParent    <= '0;
      entryChild     <= '0;
      entryGather    <= '0;
      entryIssued    <= '0;
      entryCommitted <= '0;
      entryResult    <= '0;
      repValid       <= 1'b0;
      repFlow        <= '0;
      repMask        <= '0;
      respValid      <= 1'b0;
      respFlow       <= '0;
      respPort       <= '0;
      respData       <= '0;
    end else begin
      repValid  <= 1'b0;
      respValid <= 1'b0;
      if (strobe.alloc) begin
        entryValid[strobeIdx]  <= 1'b1;
        entryFlow[strobeIdx]   <= evFlow;
        entryOp[strobeIdx]     <= evOp;
        entryParent[strobeIdx] <= evPrevPort;
      end
      if (strobe.act) begin
        entryChild[strobeIdx]     <= newChild;
        entryGather[strobeIdx]    <= baseGather || strobe.setGather;
        entryIssued[strobeIdx]    <= baseIss + CNT_W'(strobe.incIssue);
        entryCommitted[strobeIdx] <= baseCom + CNT_W'(strobe.incCommit);
        entryResult[strobeIdx]    <= newResult;
      end
      if (strobe.setGather && (baseChild != '0)) begin
        repValid <= 1'b1;
        repFlow  <= evFlow;
        repMask  <= baseChild;
      end
      if (strobe.retire) begin
        entryValid[strobeIdx] <= 1'b0;
        respValid <= 1'b1;
        respFlow  <= entryFlow[strobeIdx];
        respPort  <= entryParent[strobeIdx];
        respData  <= newResult;
      end
    end
  end

  assert_alloc_adds_one_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.alloc |=> ($countones(entryValid) == $past($countones(entryValid)) + 1));
  assert_retire_frees_one_R7: assert property (@(posedge clk) disable iff (!rstN)
    respValid |-> ($countones(entryValid) + 1 == $past($countones(entryValid))));
  assert_rep_follows_gather_R3: assert property (@(posedge clk) disable iff (!rstN)
    repValid |-> ($past(evValid) && ($past(evKind) == EV_GATH_REQ) && (repMask != '0)));
  assert_resp_counts_match_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.retire |-> (evKind != EV_UPD_LOCAL));
endmodule

// File: rtl/flow_reduce_table.sv
module flow_reduce_table
  import flow_reduce_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter int FLOW_W      = 8,
  parameter int NUM_PORTS   = 4,
  parameter int DATA_W      = 16,
  parameter int CNT_W       = 8,
  localparam int IDX_W      = $clog2(NUM_ENTRIES),
  localparam int PORT_W     = $clog2(NUM_PORTS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 evValid,
  output logic                 evReady,
  input  logic [2:0]           evKind,
  input  logic [FLOW_W-1:0]    evFlow,
  input  logic [2:0]           evOp,
  input  logic [PORT_W-1:0]    evPrevPort,
  input  logic [PORT_W-1:0]    evNextPort,
  input  logic [DATA_W-1:0]    evData,
  output logic                 repValid,
  output logic [FLOW_W-1:0]    repFlow,
  output logic [NUM_PORTS-1:0] repMask,
  output logic                 respValid,
  output logic [FLOW_W-1:0]    respFlow,
  output logic [PORT_W-1:0]    respPort,
  output logic [DATA_W-1:0]    respData
);
  tblStrobe_t                             strobe;
  logic [IDX_W-1:0]                       strobeIdx;
  logic [NUM_ENTRIES-1:0]                 entryValid;
  logic [NUM_ENTRIES-1:0][FLOW_W-1:0]     entryFlow;
  logic [NUM_ENTRIES-1:0][NUM_PORTS-1:0]  entryChild;
  logic [NUM_ENTRIES-1:0]                 entryGather;
  logic [NUM_ENTRIES-1:0][CNT_W-1:0]      entryIssued;
  logic [NUM_ENTRIES-1:0][CNT_W-1:0]      entryCommitted;

  flow_reduce_ctrl #(
    .NUM_ENTRIES(NUM_ENTRIES), .FLOW_W(FLOW_W), .NUM_PORTS(NUM_PORTS), .CNT_W(CNT_W)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .evValid(evValid), .evReady(evReady), .evKind(evKind),
    .evFlow(evFlow), .evPrevPort(evPrevPort), .evNextPort(evNextPort),
    .entryValid(entryValid), .entryFlow(entryFlow), .entryChild(entryChild),
    .entryGather(entryGather), .entryIssued(entryIssued), .entryCommitted(entryCommitted),
    .strobe(strobe), .strobeIdx(strobeIdx)
  );

  flow_reduce_data #(
    .NUM_ENTRIES(NUM_ENTRIES), .FLOW_W(FLOW_W), .NUM_PORTS(NUM_PORTS),
    .DATA_W(DATA_W), .CNT_W(CNT_W)
  ) data_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .strobeIdx(strobeIdx), .evKind(evKind),
    .evValid(evValid), .evFlow(evFlow), .evOp(evOp), .evPrevPort(evPrevPort),
    .evNextPort(evNextPort), .evData(evData),
    .entryValid(entryValid), .entryFlow(entryFlow), .entryChild(entryChild),
    .entryGather(entryGather), .entryIssued(entryIssued), .entryCommitted(entryCommitted),
    .repValid(repValid), .repFlow(repFlow), .repMask(repMask),
    .respValid(respValid), .respFlow(respFlow), .respPort(respPort), .respData(respData)
  );
endmodule

// File: tb/flow_reduce_table_tb.sv
module flow_reduce_table_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        evValid = 1'b0;
  logic        evReady;
  logic [2:0]  evKind = '0;
  logic [7:0]  evFlow = '0;
  logic [2:0]  evOp = '0;
  logic [1:0]  evPrevPort = '0;
  logic [1:0]  evNextPort = '0;
  logic [15:0] evData = '0;
  logic        repValid;
  logic [7:0]  repFlow;
  logic [3:0]  repMask;
  logic        respValid;
  logic [7:0]  respFlow;
  logic [1:0]  respPort;
  logic [15:0] respData;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  flow_reduce_table dut_i (
    .clk(clk), .rstN(rstN), .evValid(evValid), .evReady(evReady), .evKind(evKind),
    .evFlow(evFlow), .evOp(evOp), .evPrevPort(evPrevPort), .evNextPort(evNextPort),
    .evData(evData), .repValid(repValid), .repFlow(repFlow), .repMask(repMask),
    .respValid(respValid), .respFlow(respFlow), .respPort(respPort), .respData(respData)
  );

  typedef struct packed {
    logic [2:0]  kind;
    logic [7:0]  flow;
    logic [2:0]  op;
    logic [1:0]  prev;
    logic [1:0]  next;
    logic [15:0] data;
    logic        eResp;
    logic [1:0]  ePort;
    logic [15:0] eData;
    logic        eRep;
    logic [3:0]  eMask;
  } vec_t;

  localparam int NV = 33;
  localparam vec_t VEC [NV] = '{
    '{3'd0, 8'd5, 3'd0, 2'd2, 2'd0, 16'd0,      1'b0, 2'd0, 16'd0,      1'b0, 4'b0000},
    '{3'd0, 8'd9, 3'd4, 2'd0, 2'd0, 16'd0,      1'b0, 2'd0, 16'd0,      1'b0, 4'b0000},
    '{3'd1, 8'd5, 3'd0, 2'd2, 2'd1, 16'd0,      1'b0, 2'd0, 16'd0,      1'b0, 4'b0000},
    '{3'd2, 8'd5, 3'd0, 2'd0, 2'd0, 16'd10,     1'b0, 2'd0, 16'd0,      1'b0, 4'b0000},
    '{3'd0, 8'd5, 3'd0, 2'd2, 2'd0, 16'd0,      1'b0, 2'd0, 16'd0,      1'b0, 4'b0000},
    '{3'd3, 8'd5, 3'd0, 2'd0, 2'd0, 16'd0,      1'b0, 2'd0, 16'd0,      1'b1, 4'b0010},
    '{3'd0, 8'd9, 3'd4, 2'd0, 2'd0, 16'd0,      1'b0, 2'd0, 16'd0,      1'b0, 4'b0000},
    '{3'd4, 8'd5, 3'd0, 2'd1, 2'd0, 16'd7,      1'b0, 2'd0, 16'd0,      1'b0, 4'b0000},
    '{3'd2, 8'd5, 3'd0, 2'd0, 2'd0, 16'd3,      1'b1, 2'd2, 16'd20,     1'b0, 4'b0000},
    '{3'd2, 8'd9, 3'd0, 2'd0, 2'd0, 16'd50,     1'b0, 2'd0, 16'd0,      1'b0, 4'b0000},
    '{3'd3, 8'd9, 3'd0, 2'd0, 2'd0, 16'd0,      1'b0, 2'd0, 16'd0,      1'b0, 4'b0000},
    '{3'd2, 8'd9, 3'd0, 2'd0, 2'd0, 16'd30,     1'b1, 2'd0, 16'd30,     1'b0, 4'b0000},
    '{3'd0, 8'd3, 3'd5, 2'd3, 2'd0, 16'd0,      1'b0, 2'd0, 16'd0,      1'b0, 4'b0000},
    '{3'd2, 8'd3, 3'd0, 2'd0, 2'd0, 16'd4,      1'b0, 2'd0, 16'd0,      1'b0, 4'b0000},
    '{3'd1, 8'd3, 3'd5, 2'd3, 2'd0, 16'd0,      1'b0, 2'd0, 16'd0,      1'b0, 4'b0000},
    '{3'd1, 8'd3, 3'd5, 2'd3, 2'd2, 16'd0,      1'b0, 2'd0, 16'd0,      1'b0, 4'b0000},
    '{3'd3, 8'd3, 3'd0, 2'd0, 2'd0, 16'd0,      1'b0, 2'd0, 16'd0,      1'b1, 4'b0101},
    '{3'd4, 8'd3, 3'd0, 2'd0, 2'd0, 16'd9,      1'b0, 2'd0, 16'd0,      1'b0, 4'b0000},
    '{3'd4, 8'd3, 3'd0, 2'd2, 2'd0, 16'd6,      1'b1, 2'd3, 16'd9,      1'b0, 4'b0000},
    '{3'd0, 8'd7, 3'd3, 2'd1, 2'd0, 16'd0,      1'b0, 2'd0, 16'd0,      1'b0, 4'b0000},
    '{3'd2, 8'd7, 3'd0, 2'd0, 2'd0, 16'h0F0F,   1'b0, 2'd0, 16'd0,      1'b0, 4'b0000},
    '{3'd3, 8'd7, 3'd0, 2'd0, 2'd0, 16'd0,      1'b1, 2'd1, 16'h0F0F,   1'b0, 4'b0000},
    '{3'd0, 8'd8, 3'd1, 2'd1, 2'd0, 16'd0,      1'b0, 2'd0, 16'd0,      1'b0, 4'b0000},
    '{3'd2, 8'd8, 3'd0, 2'd0, 2'd0, 16'h00FF,   1'b0, 2'd0, 16'd0,      1'b0, 4'b0000},
    '{3'd0, 8'd8, 3'd1, 2'd1, 2'd0, 16'd0,      1'b0, 2'd0, 16'd0,      1'b0, 4'b0000},
    '{3'd2, 8'd8, 3'd0, 2'd0, 2'd0, 16'h0F0F,   1'b0, 2'd0, 16'd0,      1'b0, 4'b0000},
    '{3'd3, 8'd8, 3'd0, 2'd0, 2'd0, 16'd0,      1'b1, 2'd1, 16'h0FF0,   1'b0, 4'b0000},
    '{3'd1, 8'd2, 3'd2, 2'd0, 2'd3, 16'd0,      1'b0, 2'd0, 16'd0,      1'b0, 4'b0000},
    '{3'd3, 8'd2, 3'd0, 2'd0, 2'd0, 16'd0,      1'b0, 2'd0, 16'd0,      1'b1, 4'b1000},
    '{3'd4, 8'd2, 3'd0, 2'd3, 2'd0, 16'd100,    1'b1, 2'd0, 16'd100,    1'b0, 4'b0000},
    '{3'd3, 8'h44, 3'd0, 2'd0, 2'd0, 16'd0,     1'b0, 2'd0, 16'd0,      1'b0, 4'b0000},
    '{3'd2, 8'h45, 3'd0, 2'd0, 2'd0, 16'd5,     1'b0, 2'd0, 16'd0,      1'b0, 4'b0000},
    '{3'd4, 8'h46, 3'd0, 2'd1, 2'd0, 16'd8,     1'b0, 2'd0, 16'd0,      1'b0, 4'b0000}
  };

  function automatic string tagOf(input logic [2:0] kind, input logic [7:0] flow);
    if (flow >= 8'h44) return "R9";
    case (kind)
      3'd0: return "R2/R4";
      3'd1: return "R3";
      3'd2: return "R4/R5";
      3'd3: return "R3/R7";
      default: return "R6/R7";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic sendEv(input logic [2:0] kind, input logic [7:0] flow, input logic [2:0] op,
                        input logic [1:0] prev, input logic [1:0] next, input logic [15:0] data);
    @(negedge clk);
    evKind = kind; evFlow = flow; evOp = op; evPrevPort = prev; evNextPort = next; evData = data;
    evValid = 1'b1;
    @(posedge clk);
    #1;
    evValid = 1'b0;
  endtask

  task automatic peekReady(input logic [2:0] kind, input logic [7:0] flow, output logic rdy);
    @(negedge clk);
    evKind = kind; evFlow = flow; evOp = 3'd0; evValid = 1'b1;
    #1;
    rdy = evReady;
    evValid = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic rdy;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    check(evReady === 1'b1 && respValid === 1'b0 && repValid === 1'b0, "R1", "reset outputs",
          {29'd0, evReady, respValid, repValid}, 32'h4);
    @(negedge clk);
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      sendEv(VEC[i].kind, VEC[i].flow, VEC[i].op, VEC[i].prev, VEC[i].next, VEC[i].data);
      check(respValid === VEC[i].eResp &&
            (!VEC[i].eResp || (respData === VEC[i].eData && respPort === VEC[i].ePort &&
                               respFlow === VEC[i].flow)) &&
            repValid === VEC[i].eRep &&
            (!VEC[i].eRep || (repMask === VEC[i].eMask && repFlow === VEC[i].flow)),
            tagOf(VEC[i].kind, VEC[i].flow), $sformatf("vector %0d resp/rep", i),
            {respValid, respPort, respData, repValid, repMask, 8'd0},
            {VEC[i].eResp, VEC[i].ePort, VEC[i].eData, VEC[i].eRep, VEC[i].eMask, 8'd0});
    end

    // R8: fill every record, then a new flow must stall
    for (int f = 0; f < 16; f++) begin
      peekReady(3'd0, 8'(100 + f), rdy);
      check(rdy === 1'b1, "R8", "ready while filling", {31'd0, rdy}, 32'd1);
      sendEv(3'd0, 8'(100 + f), 3'd0, 2'd1, 2'd0, 16'd0);
    end
    peekReady(3'd0, 8'd150, rdy);
    check(rdy === 1'b0, "R8", "new flow stalls when full", {31'd0, rdy}, 32'd0);
    peekReady(3'd2, 8'd100, rdy);
    check(rdy === 1'b1, "R8", "known flow accepted when full", {31'd0, rdy}, 32'd1);
    // R9: non-update for unknown flow is taken, no output, no stall
    peekReady(3'd3, 8'd151, rdy);
    check(rdy === 1'b1, "R9", "gather for unknown flow taken", {31'd0, rdy}, 32'd1);
    sendEv(3'd3, 8'd151, 3'd0, 2'd0, 2'd0, 16'd0);
    check(respValid === 1'b0 && repValid === 1'b0, "R9", "no output for unknown flow",
          {30'd0, respValid, repValid}, 32'd0);
    // R4: gather before commit must not retire; commit then retires
    sendEv(3'd3, 8'd100, 3'd0, 2'd0, 2'd0, 16'd0);
    check(respValid === 1'b0, "R4", "no retire with counts unequal", {31'd0, respValid}, 32'd0);
    sendEv(3'd2, 8'd100, 3'd0, 2'd0, 2'd0, 16'd42);
    check(respValid === 1'b1 && respData === 16'd42 && respPort === 2'd1 && respFlow === 8'd100,
          "R7", "retire after last commit", {15'd0, respValid, respData}, {15'd0, 1'b1, 16'd42});
    #4;
    check(respValid === 1'b0, "R7", "response is one cycle", {31'd0, respValid}, 32'd0);
    peekReady(3'd0, 8'd150, rdy);
    check(rdy === 1'b1, "R8", "stall cleared after free", {31'd0, rdy}, 32'd1);
    // R2: second update keeps parent and opcode (MIN identity all ones kept by first op)
    sendEv(3'd0, 8'd150, 3'd4, 2'd3, 2'd0, 16'd0);
    sendEv(3'd0, 8'd150, 3'd0, 2'd0, 2'd0, 16'd0);
    sendEv(3'd2, 8'd150, 3'd0, 2'd0, 2'd0, 16'd900);
    sendEv(3'd2, 8'd150, 3'd0, 2'd0, 2'd0, 16'd700);
    sendEv(3'd3, 8'd150, 3'd0, 2'd0, 2'd0, 16'd0);
    check(respValid === 1'b1 && respPort === 2'd3 && respData === 16'd700, "R2",
          "parent and opcode kept from first update", {14'd0, respPort, respData},
          {14'd0, 2'd3, 16'd700});

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule